// File: doc/BRIEF.md
# Tone-Pair Steering and Code Register

This block sits behind a dual-tone detector. It turns the detector's raw "pair present" flag and its 4-bit key code into one registered key event per keypress. A tone is accepted only after the flag has stayed high without a break for a programmable accept guard time. The key code is then captured into an output register. A guard indication goes active at that moment. After a fixed settle delay, a delayed strobe tells the host that a key is ready.

The strobe stays high until the tone has been absent for a programmable release guard time. A short drop-out in the middle of a keypress therefore does not split it into two keys. While the strobe is high, no new code is captured, even if a different pair appears. The captured code is driven onto a shared 4-bit bus only while the output enable is high. Otherwise the bus floats.

Both guard times count pulses of a 1 ms enable input, so they replace an analog timing network with counters. Minimum recognised tone length is the detector latency plus the accept guard. Minimum inter-digit gap is the detector's release latency plus the release guard. All pins are plain level signals. There is no handshake and no back-pressure: the host reads the bus while the strobe is high, and a key event is never queued.

Top module: `tone_steer`

## Requirements
- R1: When `early_det` has been high without a break for `accept_ticks` pulses of `tick_ms`, the value on `code_in` in that cycle is captured into the code register.
- R2: A burst of `early_det` shorter than the accept guard registers nothing. Any low cycle during acceptance restarts the count from zero, so two short bursts never add up.
- R3: `guard_active` goes high in the cycle after registration. It stays high only while `early_det` is high and a key is registered or being released, and is low in every other case.
- R4: `key_strobe` rises exactly `SETTLE_CYC` clock cycles after the `guard_active` rise that marks a registration (`SETTLE_CYC` ≥ 2).
- R5: `key_strobe` falls only after `early_det` has been low without a break for `release_ticks` pulses. A shorter drop-out leaves the strobe high, and the release count restarts when the flag returns.
- R6: While `key_strobe` is high, the code register holds its value, whatever `code_in` does. A new code is taken only after the release has completed.
- R7: `code_bus` carries the code register (bit 3 is the MSB) while `out_en` is 1, and is high impedance on all four bits while `out_en` is 0.
- R8: After reset, `key_strobe` and `guard_active` are 0 and the code register holds 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond; timebase for both guards |
| early_det | input | 1 | Raw pair-present flag from the detector |
| code_in | input | 4 | Key code of the detected pair |
| accept_ticks | input | 16 | Accept guard length in ticks |
| release_ticks | input | 16 | Release guard length in ticks |
| out_en | input | 1 | Bus drive enable, active high |
| key_strobe | output | 1 | Delayed strobe: a registered key is available |
| guard_active | output | 1 | High from registration while the flag stays high |
| code_bus | output | 4 | Captured code, tri-stated when `out_en` is 0 |

## Verification
The bench sends clean keypresses that are long enough to register, and checks each capture against a queue of expected codes. Bursts shorter than the accept guard, and two short bursts separated by a one-cycle gap, must produce no strobe at all; this separates a restarting accept counter from one that keeps counting across the gap. A registered key is then broken by a drop-out shorter than the release guard while `code_in` changes. The strobe must survive and the old code must remain, which separates drop-out tolerance and the capture lock from a naive edge-triggered latch. Finally, the output enable is toggled with a known code captured, to show that the bus is driven and released.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCEPT,
    ST_SETTLE,
    ST_HELD,
    ST_RELEASE
  } steer_st_e;
endpackage

// File: rtl/steer_guard_timer.sv
// Tick-driven guard counter: saturates once the limit is reached.
module steer_guard_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         reached
);
  logic [W-1:0] cnt;

  assign reached = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (tick && !reached) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/steer_settle.sv
// Fixed clock-cycle delay between code capture and strobe.
module steer_settle #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/steer_code_latch.sv
// Code register with tri-state bus driver.
module steer_code_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         oe,
  output logic [W-1:0] q,
  output logic [W-1:0] bus
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  assign bus = oe ? q : {W{1'bz}};
endmodule

// File: rtl/tone_steer.sv
module tone_steer #(
  parameter int CODE_W     = 4,
  parameter int GUARD_W    = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_ms,
  input  logic               early_det,
  input  logic [CODE_W-1:0]  code_in,
  input  logic [GUARD_W-1:0] accept_ticks,
  input  logic [GUARD_W-1:0] release_ticks,
  input  logic               out_en,
  output logic               key_strobe,
  output logic               guard_active,
  output logic [CODE_W-1:0]  code_bus
);
  import steer_pkg::*;

  steer_st_e          state, state_nx;
  logic               acc_clr, acc_done;
  logic               rel_clr, rel_done;
  logic               settle_run, settle_done;
  logic               capture;
  logic [CODE_W-1:0]  latched_code;

  assign acc_clr    = (state != ST_ACCEPT) || !early_det;
  assign rel_clr    = (state != ST_RELEASE) || early_det;
  assign settle_run = (state == ST_SETTLE);
  assign capture    = (state == ST_ACCEPT) && early_det && acc_done;

  steer_guard_timer #(.W(GUARD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .tick(tick_ms),
    .limit(accept_ticks), .reached(acc_done)
  );

  steer_guard_timer #(.W(GUARD_W)) u_rel (
    .clk(clk), .rst_n(rst_n), .clr(rel_clr), .tick(tick_ms),
    .limit(release_ticks), .reached(rel_done)
  );

  steer_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(settle_run), .done(settle_done)
  );

  steer_code_latch #(.W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(capture), .d(code_in),
    .oe(out_en), .q(latched_code), .bus(code_bus)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (early_det) state_nx = ST_ACCEPT;
      ST_ACCEPT: begin
        if (!early_det)    state_nx = ST_IDLE;
        else if (acc_done) state_nx = ST_SETTLE;
      end
      ST_SETTLE:  if (settle_done) state_nx = ST_HELD;
      ST_HELD:    if (!early_det) state_nx = ST_RELEASE;
      ST_RELEASE: begin
        if (early_det)     state_nx = ST_HELD;
        else if (rel_done) state_nx = ST_IDLE;
      end
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign key_strobe   = (state == ST_HELD) || (state == ST_RELEASE);
  assign guard_active = early_det &&
                        ((state == ST_SETTLE) || (state == ST_HELD) || (state == ST_RELEASE));
endmodule

// File: rtl/tone_steer_chk.sv
module tone_steer_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              early_det,
  input logic              key_strobe,
  input logic              guard_active,
  input logic [CODE_W-1:0] latched_code
);
  // R4
  guard_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(guard_active) && !$past(key_strobe)) |-> !key_strobe);

  // R5
  strobe_fall_needs_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_strobe) |-> !$past(early_det));

  // R6
  code_frozen_while_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(key_strobe) |-> (latched_code == $past(latched_code)));

  // R1
  capture_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_code != $past(latched_code)) |-> $past(early_det));
endmodule

bind tone_steer tone_steer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .early_det(early_det),
  .key_strobe(key_strobe), .guard_active(guard_active),
  .latched_code(latched_code)
);

// File: tb/tone_steer_tb_top.sv
module tone_steer_tb_top;
  localparam int TP     = 4;   // clocks per tick
  localparam int ACC_G  = 3;
  localparam int REL_G  = 3;
  localparam int SETTLE = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic tick_ms = 0;
  logic early_det = 0;
  logic [3:0] code_in = 0;
  logic out_en = 1;
  logic key_strobe, guard_active;
  tri1  [3:0] bus_w;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt    <= (tcnt == TP - 1) ? 0 : tcnt + 1;
    tick_ms <= (tcnt == TP - 1);
  end

  tone_steer #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .early_det(early_det),
    .code_in(code_in), .accept_ticks(16'(ACC_G)), .release_ticks(16'(REL_G)),
    .out_en(out_en), .key_strobe(key_strobe), .guard_active(guard_active),
    .code_bus(bus_w)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: one keypress; a long enough press is pushed as an expected event.
  task automatic press(input logic [3:0] c, input int hold);
    @(negedge clk);
    code_in = c;
    early_det = 1;
    if (hold > (ACC_G + 1) * TP + SETTLE + 2) exp_q.push_back(c);
    repeat (hold) @(negedge clk);
    early_det = 0;
  endtask

  // Monitor / scoreboard
  logic p_strobe = 0, p_guard = 0, p_early = 0;
  int cnt_e = 0, cnt_g = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (early_det && !p_early) cnt_e = 0; else cnt_e++;
      if (guard_active && !p_guard) begin
        cnt_g = 0;
        if (!key_strobe) begin
          // R1: registration after the accept guard, not before
          checks++;
          if (cnt_e < (ACC_G - 1) * TP || cnt_e > (ACC_G + 1) * TP + 2) begin
            fails++;
            $display("FAIL R1: actual %0d cycles expected %0d..%0d", cnt_e,
                     (ACC_G - 1) * TP, (ACC_G + 1) * TP + 2);
          end
        end
      end else cnt_g++;
      // R3: guard only while flag high
      if (guard_active && !early_det) begin
        checks++; fails++;
        $display("FAIL R3: actual guard 1 expected 0 with flag low");
      end
      if (key_strobe && !p_strobe) begin
        // R4: settle delay
        checks++;
        if (cnt_g != SETTLE) begin
          fails++;
          $display("FAIL R4: actual %0d expected %0d", cnt_g, SETTLE);
        end
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: actual strobe with code %h expected no event", bus_w);
        end else begin
          chk("R1", bus_w, exp_q.pop_front());
        end
      end
    end
    p_strobe = key_strobe; p_guard = guard_active; p_early = early_det;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", {3'b0, key_strobe}, 4'h0);
    chk("R8", {3'b0, guard_active}, 4'h0);
    chk("R8", bus_w, 4'h0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    press(4'h5, 30);
    repeat (REL_G * TP + 10) @(negedge clk);
    chk("R5", {3'b0, key_strobe}, 4'h0);

    // R2: short burst
    press(4'h9, 6);
    repeat (20) @(negedge clk);
    chk("R2", bus_w, 4'h5);
    // R2: two short bursts split by one low cycle
    press(4'hA, 8);
    press(4'hA, 8);
    repeat (20) @(negedge clk);
    chk("R2", bus_w, 4'h5);
    chk("R2", {3'b0, key_strobe}, 4'h0);

    // R5/R6: drop-out shorter than release guard, code changes meanwhile
    press(4'hC, 30);
    repeat (5) @(negedge clk);
    chk("R5", {3'b0, key_strobe}, 4'h1);
    code_in = 4'h3;
    early_det = 1;
    repeat (20) @(negedge clk);
    chk("R6", bus_w, 4'hC);
    chk("R3", {3'b0, guard_active}, 4'h1);
    early_det = 0;
    @(negedge clk);
    chk("R3", {3'b0, guard_active}, 4'h0);
    repeat (REL_G * TP + 10) @(negedge clk);
    chk("R5", {3'b0, key_strobe}, 4'h0);
    chk("R6", bus_w, 4'hC);

    // R7: bus float / drive
    out_en = 0;
    @(negedge clk);
    chk("R7", bus_w, 4'hF);
    out_en = 1;
    @(negedge clk);
    chk("R7", bus_w, 4'hC);

    // New pair accepted after release
    press(4'h7, 30);
    repeat (REL_G * TP + 10) @(negedge clk);
    chk("R6", bus_w, 4'h7);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: actual %0d pending expected 0", exp_q.size());
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule